// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card-side bus clock of an SD/MMC host from a faster kernel clock. A small configuration register holds the divide value, a power-save enable, a launch-phase select, the bus width, a double-data-rate enable and a flow-control enable. Software writes this register only while the host's command and data engines are idle. A write made while either engine reports itself busy is dropped. The stored fields are also presented on output ports so that neighbouring logic can read them.

The divider is a four-state machine. After reset it sits in `S_STOP` with the card clock low.
- `STOP_TO_HIGH`: with a nonzero divide value and the clock allowed to run, it goes to `S_HIGH`.
- `HIGH_TO_LOW`: after `div` input cycles in `S_HIGH`, it goes to `S_LOW`.
- At the end of `div` cycles in `S_LOW` it reaches the low-phase boundary. There it loads any new divide value and restarts its phase counter. It then takes one of three exits:
  - `LOW_TO_HIGH` when the clock keeps running.
  - `LOW_TO_STOP` when power saving is on and the bus is idle.
  - `LOW_TO_BYP` when the divide value is zero.
- `STOP_TO_BYP`: a zero divide value also moves `S_STOP` to the bypass state `S_BYP`.
- In `S_BYP` the input clock is passed straight through a gate. The gate opens and closes only while the input clock is low.
- `BYP_TO_STOP`: the machine leaves `S_BYP` once the divide value becomes nonzero and the gate has already closed.

Alongside the clock the block produces two strobes, one input-clock cycle wide:
- `launch_o` marks the cycles in which the command line may change.
- `ddr_launch_o` marks data launches after both card-clock edges when double data rate is in effect.

Top module: `sdclk_gen`

## Requirements
- R1: With divide value d > 0 and the clock running, the card clock is high for exactly d input cycles and low for exactly d input cycles, giving a frequency of input/(2·d).
- R2: With divide value 0 and the clock running, the card clock follows the input clock: it is high while the input clock is high and low while it is low. `launch_o` is held high and `ddr_launch_o` is held low.
- R3: A configuration write (`cfg_we_i` high at a rising edge) updates all six stored fields, shown on the `cfg_*_o` ports, when both `cmd_active_i` and `dat_active_i` are low. The write is ignored when either of them is high.
- R4: With power saving on and `bus_idle_i` high, the card clock stops low within one clock period and stays low. Both strobes stay low. The clock restarts after `bus_idle_i` falls.
- R5: With d > 0, every card-clock edge follows a rising input-clock edge: the card clock holds one level for the whole of each input cycle.
- R6: With d > 0, `launch_o` is high in the first input cycle after a card-clock rising edge when the launch-phase select is 0. It is high in the first input cycle after a card-clock falling edge when the select is 1. With d = 0 the select has no effect (see R2).
- R7: The width field encodes 00 = 1 bit, 01 = 4 bits, 10 = 8 bits and 11 = 1 bit. When the DDR field is 1, the width is 01 or 10, and d > 0, `ddr_launch_o` is high in the first input cycle after every card-clock edge. In all other cases it stays low.
- R8: During and directly after reset the card clock and both strobes are low and every stored field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel (input) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_div_i | input | DIV_W | Divide value to write |
| cfg_pwrsave_i | input | 1 | Power-save enable to write |
| cfg_fall_launch_i | input | 1 | Launch-phase select to write |
| cfg_width_i | input | 2 | Bus width code to write |
| cfg_ddr_i | input | 1 | Double-data-rate enable to write |
| cfg_hwfc_i | input | 1 | Flow-control enable to write |
| cmd_active_i | input | 1 | Command engine busy |
| dat_active_i | input | 1 | Data engine busy |
| bus_idle_i | input | 1 | Bus has no traffic pending |
| card_clk_o | output | 1 | Card bus clock |
| launch_o | output | 1 | Command launch strobe |
| ddr_launch_o | output | 1 | Double-rate data launch strobe |
| cfg_div_o | output | DIV_W | Stored divide value |
| cfg_pwrsave_o | output | 1 | Stored power-save enable |
| cfg_fall_launch_o | output | 1 | Stored launch-phase select |
| cfg_width_o | output | 2 | Stored bus width code |
| cfg_ddr_o | output | 1 | Stored double-data-rate enable |
| cfg_hwfc_o | output | 1 | Stored flow-control enable |

## Verification
The assertions assume that `bus_idle_i`, the busy flags and the configuration inputs change away from the input clock's edges, and that the divide value fits in `DIV_W` bits. The phase-length check also assumes that the divide value in use changes only at the low-phase boundary.

The stimulus drives every input a quarter period after the falling edge, so the rising-edge registers and the falling-edge bypass gate both see settled values. Random divide values are drawn from 0 to 7. After each reconfiguration the bench waits longer than the longest old phase before it measures anything.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    typedef enum logic [1:0] {
        S_STOP = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2,
        S_BYP  = 2'd3
    } ck_state_e;

    localparam logic [1:0] BUS_1B  = 2'b00;
    localparam logic [1:0] BUS_4B  = 2'b01;
    localparam logic [1:0] BUS_8B  = 2'b10;

    function automatic logic ddr_allowed(input logic ddr, input logic [1:0] width);
        return ddr && (width == BUS_4B || width == BUS_8B);
    endfunction

endpackage

// File: rtl/sdclk_cfg.sv
module sdclk_cfg #(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             cmd_busy_i,
    input  logic             dat_busy_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             pwrsave_i,
    input  logic             fall_i,
    input  logic [1:0]       width_i,
    input  logic             ddr_i,
    input  logic             hwfc_i,
    output logic [DIV_W-1:0] div_o,
    output logic             pwrsave_o,
    output logic             fall_o,
    output logic [1:0]       width_o,
    output logic             ddr_o,
    output logic             hwfc_o
);

    logic accept;
    assign accept = we_i && !cmd_busy_i && !dat_busy_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_o     <= '0;
            pwrsave_o <= 1'b0;
            fall_o    <= 1'b0;
            width_o   <= '0;
            ddr_o     <= 1'b0;
            hwfc_o    <= 1'b0;
        end else if (accept) begin
            div_o     <= div_i;
            pwrsave_o <= pwrsave_i;
            fall_o    <= fall_i;
            width_o   <= width_i;
            ddr_o     <= ddr_i;
            hwfc_o    <= hwfc_i;
        end
    end

endmodule

// File: rtl/sdclk_fsm.sv
module sdclk_fsm
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_cfg_i,
    input  logic             run_i,
    output ck_state_e        state_o,
    output logic             first_o,
    output logic [DIV_W-1:0] div_act_o,
    output logic             gate_o
);

    ck_state_e        st_q, st_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] div_q, div_d;
    logic             gate_q;
    logic             last;
    logic             cfg_zero;

    assign cfg_zero = (div_cfg_i == '0);
    assign last     = (cnt_q == div_q - 1'b1);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= S_STOP;
            cnt_q <= '0;
            div_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            div_q <= div_d;
        end
    end

    // bypass gate moves only while the input clock is low
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= (st_q == S_BYP) && cfg_zero && run_i;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        div_d = div_q;
        unique case (st_q)
            S_STOP: begin
                if (cfg_zero) begin
                    st_d = S_BYP;
                end else if (run_i) begin
                    st_d  = S_HIGH;
                    div_d = div_cfg_i;
                    cnt_d = '0;
                end
            end
            S_HIGH: begin
                if (last) begin
                    st_d  = S_LOW;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_LOW: begin
                if (last) begin
                    cnt_d = '0;
                    div_d = div_cfg_i;
                    if (cfg_zero) begin
                        st_d = S_BYP;
                    end else if (!run_i) begin
                        st_d = S_STOP;
                    end else begin
                        st_d = S_HIGH;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            S_BYP: begin
                if (!cfg_zero && !gate_q) begin
                    st_d = S_STOP;
                end
            end
            default: st_d = S_STOP;
        endcase
    end

    // outputs
    always_comb begin
        state_o   = st_q;
        first_o   = (cnt_q == '0);
        div_act_o = div_q;
        gate_o    = gate_q;
    end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_we_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             cfg_pwrsave_i,
    input  logic             cfg_fall_launch_i,
    input  logic [1:0]       cfg_width_i,
    input  logic             cfg_ddr_i,
    input  logic             cfg_hwfc_i,
    input  logic             cmd_active_i,
    input  logic             dat_active_i,
    input  logic             bus_idle_i,
    output logic             card_clk_o,
    output logic             launch_o,
    output logic             ddr_launch_o,
    output logic [DIV_W-1:0] cfg_div_o,
    output logic             cfg_pwrsave_o,
    output logic             cfg_fall_launch_o,
    output logic [1:0]       cfg_width_o,
    output logic             cfg_ddr_o,
    output logic             cfg_hwfc_o
);

    ck_state_e        st;
    logic             first;
    logic [DIV_W-1:0] div_act;
    logic             gate;
    logic             run;
    logic             div_clk;
    logic             ddr_on;

    sdclk_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (cfg_we_i),
        .cmd_busy_i (cmd_active_i),
        .dat_busy_i (dat_active_i),
        .div_i      (cfg_div_i),
        .pwrsave_i  (cfg_pwrsave_i),
        .fall_i     (cfg_fall_launch_i),
        .width_i    (cfg_width_i),
        .ddr_i      (cfg_ddr_i),
        .hwfc_i     (cfg_hwfc_i),
        .div_o      (cfg_div_o),
        .pwrsave_o  (cfg_pwrsave_o),
        .fall_o     (cfg_fall_launch_o),
        .width_o    (cfg_width_o),
        .ddr_o      (cfg_ddr_o),
        .hwfc_o     (cfg_hwfc_o)
    );

    assign run = !(cfg_pwrsave_o && bus_idle_i);

    sdclk_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .div_cfg_i (cfg_div_o),
        .run_i     (run),
        .state_o   (st),
        .first_o   (first),
        .div_act_o (div_act),
        .gate_o    (gate)
    );

    assign div_clk    = (st == S_HIGH);
    assign ddr_on     = ddr_allowed(cfg_ddr_o, cfg_width_o);
    assign card_clk_o = div_clk | (clk_i & gate);

    always_comb begin
        launch_o     = 1'b0;
        ddr_launch_o = 1'b0;
        unique case (st)
            S_HIGH: begin
                launch_o     = first && !cfg_fall_launch_o;
                ddr_launch_o = first && ddr_on;
            end
            S_LOW: begin
                launch_o     = first && cfg_fall_launch_o;
                ddr_launch_o = first && ddr_on;
            end
            S_BYP:   launch_o = gate;
            S_STOP:  launch_o = 1'b0;
            default: launch_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_we_i,
    input logic             cmd_active_i,
    input logic             dat_active_i,
    input logic             bus_idle_i,
    input logic             launch_o,
    input logic             ddr_launch_o,
    input logic [DIV_W-1:0] cfg_div_o,
    input logic             cfg_pwrsave_o,
    input logic             cfg_fall_launch_o,
    input logic [1:0]       cfg_width_o,
    input logic             cfg_ddr_o,
    input logic             cfg_hwfc_o,
    input ck_state_e        st,
    input logic             div_clk,
    input logic [DIV_W-1:0] div_act
);

    logic [DIV_W-1:0] run_q;
    logic             prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= div_clk;
            run_q  <= (div_clk != prev_q) ? '0 : run_q + 1'b1;
        end
    end

    assert_phase_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st == S_HIGH || st == S_LOW) && div_clk == prev_q)
            |-> ({1'b0, run_q} + 1'b1 < {1'b0, div_act}));

    assert_locked_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i && (cmd_active_i || dat_active_i))
            |=> $stable({cfg_div_o, cfg_pwrsave_o, cfg_fall_launch_o,
                         cfg_width_o, cfg_ddr_o, cfg_hwfc_o}));

    assert_stop_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == S_STOP && cfg_pwrsave_o && bus_idle_i && cfg_div_o != '0)
            |=> (st == S_STOP));

    assert_launch_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (launch_o && st != S_BYP) |-> (div_clk != $past(div_clk)));

    assert_ddr_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ddr_launch_o |-> (cfg_ddr_o && (cfg_width_o == BUS_4B || cfg_width_o == BUS_8B)));

endmodule

bind sdclk_gen sdclk_gen_chk #(.DIV_W(DIV_W)) u_sdclk_gen_chk (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .cfg_we_i          (cfg_we_i),
    .cmd_active_i      (cmd_active_i),
    .dat_active_i      (dat_active_i),
    .bus_idle_i        (bus_idle_i),
    .launch_o          (launch_o),
    .ddr_launch_o      (ddr_launch_o),
    .cfg_div_o         (cfg_div_o),
    .cfg_pwrsave_o     (cfg_pwrsave_o),
    .cfg_fall_launch_o (cfg_fall_launch_o),
    .cfg_width_o       (cfg_width_o),
    .cfg_ddr_o         (cfg_ddr_o),
    .cfg_hwfc_o        (cfg_hwfc_o),
    .st                (st),
    .div_clk           (div_clk),
    .div_act           (div_act)
);

// File: tb/sdclk_gen_bench.sv
module sdclk_gen_bench;

    localparam int CLK_PERIOD = 12;
    localparam int QTR        = CLK_PERIOD / 4;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int DIV_W      = 10;
    localparam int SETTLE     = 40;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             cfg_we_i = 1'b0;
    logic [DIV_W-1:0] cfg_div_i = '0;
    logic             cfg_pwrsave_i = 1'b0;
    logic             cfg_fall_launch_i = 1'b0;
    logic [1:0]       cfg_width_i = '0;
    logic             cfg_ddr_i = 1'b0;
    logic             cfg_hwfc_i = 1'b0;
    logic             cmd_active_i = 1'b0;
    logic             dat_active_i = 1'b0;
    logic             bus_idle_i = 1'b0;
    logic             card_clk_o, launch_o, ddr_launch_o;
    logic [DIV_W-1:0] cfg_div_o;
    logic             cfg_pwrsave_o, cfg_fall_launch_o, cfg_ddr_o, cfg_hwfc_o;
    logic [1:0]       cfg_width_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model of stored fields
    int m_div = 0, m_ps = 0, m_fall = 0, m_w = 0, m_ddr = 0, m_hw = 0;

    // samples of the current cycle
    logic s_hi, s_lo, s_la, s_dl, s_la_hi;

    always #(HALF) clk_i = ~clk_i;

    sdclk_gen #(.DIV_W(DIV_W)) u_sdclk_gen (.*);

    function automatic bit ddr_expect(input int ddr, input int w, input int d);
        return (ddr != 0) && (w == 1 || w == 2) && (d != 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // advance one input cycle; sample mid-high and mid-low
    task automatic step();
        @(posedge clk_i);
        #(QTR);
        s_hi    = card_clk_o;
        s_la_hi = launch_o;
        #(HALF);
        s_lo = card_clk_o;
        s_la = launch_o;
        s_dl = ddr_launch_o;
    endtask

    task automatic check_cfg(input string req);
        int got;
        got = {cfg_hwfc_o, cfg_ddr_o, cfg_width_o, cfg_fall_launch_o, cfg_pwrsave_o} ;
        check(cfg_div_o == m_div[DIV_W-1:0], req, int'(cfg_div_o), m_div);
        check(got == {m_hw[0], m_ddr[0], m_w[1:0], m_fall[0], m_ps[0]}, req, got,
              int'({m_hw[0], m_ddr[0], m_w[1:0], m_fall[0], m_ps[0]}));
    endtask

    task automatic cfg_write(input int d, input int ps, input int fall, input int w,
                             input int ddr, input int hw, input bit cmd, input bit dat);
        cfg_div_i         = d[DIV_W-1:0];
        cfg_pwrsave_i     = ps[0];
        cfg_fall_launch_i = fall[0];
        cfg_width_i       = w[1:0];
        cfg_ddr_i         = ddr[0];
        cfg_hwfc_i        = hw[0];
        cmd_active_i      = cmd;
        dat_active_i      = dat;
        cfg_we_i          = 1'b1;
        step();
        cfg_we_i     = 1'b0;
        cmd_active_i = 1'b0;
        dat_active_i = 1'b0;
        if (!cmd && !dat) begin
            m_div = d; m_ps = ps; m_fall = fall; m_w = w; m_ddr = ddr; m_hw = hw;
        end
        check_cfg("R3");
    endtask

    task automatic settle();
        repeat (SETTLE) step();
    endtask

    // divided mode: R1 phase lengths, R5 stability, R6 launch, R7 ddr strobe
    task automatic check_divided(input int n);
        logic prev;
        int   runlen;
        bit   seen;
        int   edges;
        bit   rose, fell, exp_la, exp_dl;
        step();
        prev   = s_lo;
        runlen = 0;
        seen   = 0;
        edges  = 0;
        for (int i = 0; i < n; i++) begin
            step();
            check(s_hi == s_lo, "R5", int'(s_hi), int'(s_lo));
            rose   = s_lo && !prev;
            fell   = !s_lo && prev;
            exp_la = (m_fall != 0) ? fell : rose;
            exp_dl = ddr_expect(m_ddr, m_w, m_div) ? (rose || fell) : 1'b0;
            check(s_la == exp_la, "R6", int'(s_la), int'(exp_la));
            check(s_dl == exp_dl, "R7", int'(s_dl), int'(exp_dl));
            if (rose || fell) begin
                edges++;
                if (seen) check(runlen == m_div, "R1", runlen, m_div);
                seen   = 1;
                runlen = 1;
            end else begin
                runlen++;
            end
            prev = s_lo;
        end
        check(edges >= n / m_div - 1, "R1", edges, n / m_div - 1);
    endtask

    // divide-by-one: R2
    task automatic check_bypass(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            check(s_hi == 1'b1, "R2", int'(s_hi), 1);
            check(s_lo == 1'b0, "R2", int'(s_lo), 0);
            check(s_la == 1'b1 && s_la_hi == 1'b1, "R2", int'(s_la), 1);
            check(s_dl == 1'b0, "R7", int'(s_dl), 0);
        end
    endtask

    // gated: R4
    task automatic check_gated(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            check(s_hi == 1'b0 && s_lo == 1'b0, "R4", int'(s_hi | s_lo), 0);
            check(s_la == 1'b0 && s_dl == 1'b0, "R4", int'(s_la | s_dl), 0);
        end
    endtask

    task automatic check_mode(input int n);
        if (m_div == 0) check_bypass(n);
        else            check_divided(n);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        // R8: reset state
        #(CLK_PERIOD * 3 + QTR);
        check(card_clk_o == 1'b0, "R8", int'(card_clk_o), 0);
        check(launch_o == 1'b0 && ddr_launch_o == 1'b0, "R8", int'(launch_o | ddr_launch_o), 0);
        check_cfg("R8");
        @(negedge clk_i);
        #(QTR);
        rst_ni = 1'b1;
        step();
        check(s_hi == 1'b0 && s_lo == 1'b0, "R8", int'(s_hi | s_lo), 0);

        // accepted write, divided SDR
        cfg_write(3, 0, 0, 1, 0, 1, 0, 0);
        settle();
        check_divided(40);

        // R3: writes dropped while an engine is busy
        cfg_write(5, 1, 1, 2, 1, 0, 1, 0);
        cfg_write(6, 1, 1, 3, 1, 0, 0, 1);
        cfg_write(7, 0, 1, 0, 0, 0, 1, 1);
        settle();
        check_divided(40);

        // R6: falling-edge launch
        cfg_write(2, 0, 1, 0, 0, 0, 0, 0);
        settle();
        check_divided(30);

        // R7: width codes with DDR
        cfg_write(4, 0, 0, 1, 1, 0, 0, 0);
        settle();
        check_divided(40);
        cfg_write(1, 0, 1, 2, 1, 0, 0, 0);
        settle();
        check_divided(20);
        cfg_write(3, 0, 0, 0, 1, 0, 0, 0);
        settle();
        check_divided(30);
        cfg_write(3, 0, 1, 3, 1, 0, 0, 0);
        settle();
        check_divided(30);

        // R2: divide-by-one ignores fall select and DDR
        cfg_write(0, 0, 1, 1, 1, 0, 0, 0);
        settle();
        check_bypass(20);
        cfg_write(0, 0, 0, 2, 0, 1, 0, 0);
        settle();
        check_bypass(10);

        // R4: power saving, divided then bypass
        cfg_write(3, 1, 0, 1, 0, 0, 0, 0);
        bus_idle_i = 1'b1;
        settle();
        check_gated(30);
        bus_idle_i = 1'b0;
        settle();
        check_divided(30);
        cfg_write(0, 1, 0, 0, 0, 0, 0, 0);
        settle();
        check_bypass(8);
        bus_idle_i = 1'b1;
        step();
        step();
        check_gated(20);
        bus_idle_i = 1'b0;
        settle();
        check_bypass(8);

        // random mix
        for (int it = 0; it < 14; it++) begin
            int d, fall, w, ddr, hw;
            bit busy;
            d    = $urandom % 8;
            fall = $urandom % 2;
            w    = $urandom % 4;
            ddr  = $urandom % 2;
            hw   = $urandom % 2;
            busy = ($urandom % 4) == 0;
            cfg_write(d, 0, fall, w, ddr, hw, busy, 1'b0);
            settle();
            check_mode(40);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule